// File: doc/BRIEF.md
# USB Device OUT Endpoint Handshake Responder

This block decides how a USB device answers an OUT transaction aimed at one endpoint, and it keeps that endpoint's status flags and interrupt up to date. A token decoder presents each OUT token as a one-cycle pulse carrying the device address and endpoint number. The data phase then follows as a stream of byte strobes, and the last byte is marked with a packet-end flag. The block compares the token with its configured address and endpoint. It then checks the endpoint enable and its own buffer-full flag, and it either forwards every byte to the receive FIFO or throws the packet away.

When a data phase completes, the block requests a handshake from the transmitter one cycle later. A stored packet on a normal endpoint is answered with ACK. A normal endpoint whose buffer is occupied is answered with NAK. An isochronous endpoint never gets a handshake. A stored packet marks the buffer full and raises the interrupt toward the processor. The buffer stays full until the processor pulses its "buffer emptied" strobe. The interrupt stays up until the processor pulses its acknowledge strobe.

Top module: `usb_out_ep_responder`

## Requirements
- R1: After reset, fifo_wr_en, hs_valid and irq are 0 and ep_status is 3'b000.
- R2: A token whose address or endpoint number differs from cfg_dev_addr / cfg_ep_num causes no FIFO write and no handshake, and leaves irq and ep_status unchanged.
- R3: A matching token while ep_enable is 0 (sampled with the token) causes no FIFO write and no handshake, and leaves irq and ep_status unchanged.
- R4: After an accepted token with the buffer empty (ep_status[0]=0), fifo_wr_en is high in exactly the cycles where rx_byte_valid is high, up to and including the packet-end byte, and fifo_wr_data equals rx_byte in those cycles.
- R5: On a stored non-isochronous packet, in the cycle after the one carrying rx_pkt_end, hs_valid is 1 for one cycle with hs_code 2'b01 (ACK), irq becomes 1 in that same cycle and not before, and ep_status[0] (buffer full) becomes 1.
- R6: A matching, enabled, non-isochronous token that arrives while ep_status[0]=1 causes no FIFO write. In the cycle after packet end, hs_valid pulses with hs_code 2'b10 (NAK), ep_status[1] (last packet refused) is set, and irq is unchanged.
- R7: On a stored isochronous packet (ep_is_iso=1, sampled with the token), no handshake is requested. irq and ep_status[0] are set in the cycle after packet end, and ep_status[2] (last stored packet was isochronous) is set.
- R8: An isochronous packet that arrives while the buffer is full is dropped with no write and no handshake, and ep_status and irq are unchanged.
- R9: cpu_irq_ack clears irq on the next cycle. When it coincides with the cycle that stores a packet, irq ends up 1.
- R10: cpu_buf_emptied clears ep_status[0] on the next cycle, after which the next packet is accepted. Storing a packet clears ep_status[1], and it sets ep_status[2] to the isochronous flag of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dev_addr | input | 7 | Configured device address |
| cfg_ep_num | input | 4 | Configured endpoint number |
| ep_enable | input | 1 | Endpoint enabled, sampled with the token |
| ep_is_iso | input | 1 | Endpoint is isochronous, sampled with the token |
| tok_valid | input | 1 | One-cycle pulse for a decoded OUT token |
| tok_addr | input | 7 | Token device address |
| tok_ep | input | 4 | Token endpoint number |
| rx_byte_valid | input | 1 | Data-phase byte strobe |
| rx_byte | input | 8 | Data-phase byte |
| rx_pkt_end | input | 1 | Marks the final byte of the data phase |
| cpu_irq_ack | input | 1 | Processor strobe that clears the interrupt |
| cpu_buf_emptied | input | 1 | Processor strobe that frees the buffer |
| fifo_wr_en | output | 1 | FIFO write enable |
| fifo_wr_data | output | 8 | FIFO write data |
| hs_valid | output | 1 | One-cycle handshake request |
| hs_code | output | 2 | 01 ACK, 10 NAK |
| ep_status | output | 3 | [0] buffer full, [1] last packet refused, [2] last stored packet isochronous |
| irq | output | 1 | Interrupt pending |

## Verification
A packet being stored and a processor acknowledge of the interrupt can land in the same clock cycle. The bench provokes this by holding cpu_irq_ack high in the cycle that carries rx_pkt_end. It then requires irq to read 1 afterwards, and a second acknowledge on its own must bring irq to 0. The bench also checks that the ACK request and the interrupt rise in the same cycle. It checks that a refused packet leaves an already pending interrupt in place.

// File: rtl/usb_ep_pkg.sv
// Package: shared types for the OUT endpoint responder.
// Assumes: a handshake code of zero never reaches the transmitter.
package usb_ep_pkg;

    typedef enum logic [1:0] {
        HS_NONE = 2'b00,
        HS_ACK  = 2'b01,
        HS_NAK  = 2'b10
    } hs_code_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'b00,
        RX_STORE = 2'b01,
        RX_DROP  = 2'b10
    } rx_state_e;

    localparam int STAT_W    = 3;
    localparam int STAT_FULL = 0;
    localparam int STAT_NAK  = 1;
    localparam int STAT_ISO  = 2;

endpackage

// File: rtl/usb_ep_match.sv
// Module: usb_ep_match
// Compares a token's address and endpoint with the configured values and
// qualifies the result with the endpoint enable.
// Assumes: the inputs are stable for the cycle in which tok_valid is high.
module usb_ep_match #(
    parameter int ADDR_W = 7,
    parameter int EP_W   = 4
) (
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [EP_W-1:0]   cfg_ep,
    input  logic              ep_enable,
    output logic              hit
);

    // Purpose: token targets this endpoint and the endpoint is live.
    always_comb begin
        hit = (tok_addr == cfg_addr) && (tok_ep == cfg_ep) && ep_enable;
    end

endmodule

// File: rtl/usb_ep_rx_ctrl.sv
// Module: usb_ep_rx_ctrl
// Follows one OUT transaction. It picks store or drop when the token arrives,
// forwards bytes to the FIFO while storing, emits completion events on the
// packet-end byte and registers the handshake request.
// Assumes: tokens arriving during a data phase are not acted on.
module usb_ep_rx_ctrl
    import usb_ep_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic              hit,
    input  logic              buf_full,
    input  logic              ep_is_iso,
    input  logic              rx_byte_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_pkt_end,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data,
    output logic              evt_store,
    output logic              evt_drop,
    output logic              iso_q,
    output logic              hs_valid,
    output logic [1:0]        hs_code
);

    rx_state_e state_q, state_d;

    // Purpose: choose the next transaction state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (tok_valid && hit) begin
                    state_d = buf_full ? RX_DROP : RX_STORE;
                end
            end
            RX_STORE, RX_DROP: begin
                if (rx_pkt_end) begin
                    state_d = RX_IDLE;
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // Purpose: hold the state and latch the endpoint type with the token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            iso_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == RX_IDLE && tok_valid && hit) begin
                iso_q <= ep_is_iso;
            end
        end
    end

    // Purpose: FIFO write path and completion events.
    always_comb begin
        fifo_wr_en   = (state_q == RX_STORE) && rx_byte_valid;
        fifo_wr_data = rx_byte;
        evt_store    = (state_q == RX_STORE) && rx_pkt_end;
        evt_drop     = (state_q == RX_DROP) && rx_pkt_end;
    end

    // Purpose: one-cycle handshake request after the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
        end else begin
            hs_valid <= (evt_store || evt_drop) && !iso_q;
            if ((evt_store || evt_drop) && !iso_q) begin
                hs_code <= evt_store ? HS_ACK : HS_NAK;
            end else begin
                hs_code <= HS_NONE;
            end
        end
    end

endmodule

// File: rtl/usb_ep_status.sv
// Module: usb_ep_status
// Keeps the endpoint status flags and the interrupt-pending bit, and applies
// the processor clear strobes.
// Assumes: when a set and a clear fall in the same cycle, the set wins.
module usb_ep_status
    import usb_ep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_store,
    input  logic              evt_drop,
    input  logic              iso_q,
    input  logic              cpu_irq_ack,
    input  logic              cpu_buf_emptied,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    logic full_q, nak_q, iso_flag_q;

    // Purpose: buffer-full flag, set by a stored packet, cleared by the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (evt_store) begin
            full_q <= 1'b1;
        end else if (cpu_buf_emptied) begin
            full_q <= 1'b0;
        end
    end

    // Purpose: refused-packet and isochronous flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nak_q      <= 1'b0;
            iso_flag_q <= 1'b0;
        end else if (evt_store) begin
            nak_q      <= 1'b0;
            iso_flag_q <= iso_q;
        end else if (evt_drop && !iso_q) begin
            nak_q      <= 1'b1;
        end
    end

    // Purpose: interrupt-pending bit with set priority over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (evt_store) begin
            irq <= 1'b1;
        end else if (cpu_irq_ack) begin
            irq <= 1'b0;
        end
    end

    // Purpose: pack the flags into the status word.
    always_comb begin
        status            = '0;
        status[STAT_FULL] = full_q;
        status[STAT_NAK]  = nak_q;
        status[STAT_ISO]  = iso_flag_q;
    end

endmodule

// File: rtl/usb_out_ep_responder.sv
// Module: usb_out_ep_responder
// Top level: answers OUT transactions for one configured endpoint with ACK,
// NAK or no handshake. It writes accepted data to an external FIFO and keeps
// the status flags and interrupt.
// Assumes: token decoding, CRC checks and the FIFO memory sit outside.
module usb_out_ep_responder
    import usb_ep_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int EP_W   = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_dev_addr,
    input  logic [EP_W-1:0]   cfg_ep_num,
    input  logic              ep_enable,
    input  logic              ep_is_iso,
    input  logic              tok_valid,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              rx_byte_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_pkt_end,
    input  logic              cpu_irq_ack,
    input  logic              cpu_buf_emptied,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic [STAT_W-1:0] ep_status,
    output logic              irq
);

    logic hit;
    logic evt_store;
    logic evt_drop;
    logic iso_q;

    usb_ep_match #(
        .ADDR_W (ADDR_W),
        .EP_W   (EP_W)
    ) u_match (
        .tok_addr  (tok_addr),
        .tok_ep    (tok_ep),
        .cfg_addr  (cfg_dev_addr),
        .cfg_ep    (cfg_ep_num),
        .ep_enable (ep_enable),
        .hit       (hit)
    );

    usb_ep_rx_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tok_valid     (tok_valid),
        .hit           (hit),
        .buf_full      (ep_status[STAT_FULL]),
        .ep_is_iso     (ep_is_iso),
        .rx_byte_valid (rx_byte_valid),
        .rx_byte       (rx_byte),
        .rx_pkt_end    (rx_pkt_end),
        .fifo_wr_en    (fifo_wr_en),
        .fifo_wr_data  (fifo_wr_data),
        .evt_store     (evt_store),
        .evt_drop      (evt_drop),
        .iso_q         (iso_q),
        .hs_valid      (hs_valid),
        .hs_code       (hs_code)
    );

    usb_ep_status u_status (
        .clk             (clk),
        .rst_n           (rst_n),
        .evt_store       (evt_store),
        .evt_drop        (evt_drop),
        .iso_q           (iso_q),
        .cpu_irq_ack     (cpu_irq_ack),
        .cpu_buf_emptied (cpu_buf_emptied),
        .status          (ep_status),
        .irq             (irq)
    );

endmodule

// File: rtl/usb_out_ep_responder_chk.sv
// Module: usb_out_ep_responder_chk
// Property checker bound to the responder. It watches the ports only.
module usb_out_ep_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_byte_valid,
    input logic       cpu_irq_ack,
    input logic       cpu_buf_emptied,
    input logic       fifo_wr_en,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic [2:0] ep_status,
    input logic       irq
);

    // R4
    wr_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> rx_byte_valid);

    // R6
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> !ep_status[0]);

    // R5
    ack_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'b01) |-> (irq && ep_status[0]));

    // R5
    hs_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid);

    // R7
    hs_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> (hs_code == 2'b01 || hs_code == 2'b10));

    // R9
    irq_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(cpu_irq_ack));

    // R10
    full_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ep_status[0]) |-> $past(cpu_buf_emptied));

endmodule

bind usb_out_ep_responder usb_out_ep_responder_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_byte_valid   (rx_byte_valid),
    .cpu_irq_ack     (cpu_irq_ack),
    .cpu_buf_emptied (cpu_buf_emptied),
    .fifo_wr_en      (fifo_wr_en),
    .hs_valid        (hs_valid),
    .hs_code         (hs_code),
    .ep_status       (ep_status),
    .irq             (irq)
);

// File: tb/usb_out_ep_responder_test.sv
`timescale 1ns/100ps
module usb_out_ep_responder_test;

    localparam logic [6:0] MY_ADDR = 7'h2A;
    localparam logic [3:0] MY_EP   = 4'h3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ep_enable = 1'b0, ep_is_iso = 1'b0, tok_valid = 1'b0;
    logic [6:0] tok_addr = '0;
    logic [3:0] tok_ep = '0;
    logic       rx_byte_valid = 1'b0, rx_pkt_end = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       cpu_irq_ack = 1'b0, cpu_buf_emptied = 1'b0;
    logic       fifo_wr_en, hs_valid, irq;
    logic [7:0] fifo_wr_data;
    logic [1:0] hs_code;
    logic [2:0] ep_status;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int nwr;
    logic data_bad;

    always #2.5 clk = ~clk;

    usb_out_ep_responder uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_dev_addr (MY_ADDR), .cfg_ep_num (MY_EP),
        .ep_enable (ep_enable), .ep_is_iso (ep_is_iso),
        .tok_valid (tok_valid), .tok_addr (tok_addr), .tok_ep (tok_ep),
        .rx_byte_valid (rx_byte_valid), .rx_byte (rx_byte), .rx_pkt_end (rx_pkt_end),
        .cpu_irq_ack (cpu_irq_ack), .cpu_buf_emptied (cpu_buf_emptied),
        .fifo_wr_en (fifo_wr_en), .fifo_wr_data (fifo_wr_data),
        .hs_valid (hs_valid), .hs_code (hs_code),
        .ep_status (ep_status), .irq (irq)
    );

    typedef struct packed {
        logic [6:0] addr;
        logic [3:0] ep;
        logic       en;
        logic       iso;
        logic       empty_first;
        logic       ack_first;
        logic [3:0] nbytes;
        logic [3:0] exp_wr;
        logic       exp_hsv;
        logic [1:0] exp_hs;
        logic       exp_irq;
        logic [2:0] exp_st;
        logic [3:0] req;
    } vec_t;

    // Each row: token, pre-strobes, length, expected writes/handshake/irq/status.
    localparam vec_t VECS [10] = '{
        '{7'h2B, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 4'd0, 1'b0, 2'b00, 1'b0, 3'b000, 4'd2}, // R2 address
        '{7'h2A, 4'h5, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 4'd0, 1'b0, 2'b00, 1'b0, 3'b000, 4'd2}, // R2 endpoint
        '{7'h2A, 4'h3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd0, 1'b0, 2'b00, 1'b0, 3'b000, 4'd3}, // R3 disabled
        '{7'h2A, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 4'd4, 1'b1, 2'b01, 1'b1, 3'b001, 4'd5}, // R5 store+ACK
        '{7'h2A, 4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 4'd0, 1'b1, 2'b10, 1'b1, 3'b011, 4'd6}, // R6 NAK
        '{7'h2A, 4'h3, 1'b1, 1'b0, 1'b1, 1'b1, 4'd1, 4'd1, 1'b1, 2'b01, 1'b1, 3'b001, 4'd10}, // R10 refill
        '{7'h2A, 4'h3, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3, 4'd0, 1'b0, 2'b00, 1'b0, 3'b001, 4'd8}, // R8 iso full
        '{7'h2A, 4'h3, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5, 4'd5, 1'b0, 2'b00, 1'b1, 3'b101, 4'd7}, // R7 iso store
        '{7'h2A, 4'h3, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2, 4'd2, 1'b1, 2'b01, 1'b1, 3'b001, 4'd4}, // R4 writes
        '{7'h2A, 4'h3, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2, 4'd0, 1'b0, 2'b00, 1'b1, 3'b000, 4'd3}  // R3 after empty
    };

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic strobes(input logic empty_s, input logic ack_s);
        if (empty_s || ack_s) begin
            @(negedge clk);
            cpu_buf_emptied = empty_s;
            cpu_irq_ack = ack_s;
            @(negedge clk);
            cpu_buf_emptied = 1'b0;
            cpu_irq_ack = 1'b0;
        end
    endtask

    // Runs one OUT transaction; leaves the bench at the negedge after packet end.
    task automatic send_pkt(input logic [6:0] a, input logic [3:0] e, input logic en,
                            input logic iso, input int n, input logic ack_at_end);
        @(negedge clk);
        tok_valid = 1'b1; tok_addr = a; tok_ep = e; ep_enable = en; ep_is_iso = iso;
        @(negedge clk);
        tok_valid = 1'b0;
        nwr = 0;
        data_bad = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_byte_valid = 1'b1;
            rx_byte = 8'hA0 + 8'(i);
            rx_pkt_end = (i == n - 1);
            cpu_irq_ack = ack_at_end && (i == n - 1);
            #1;
            if (fifo_wr_en) begin
                nwr++;
                if (fifo_wr_data != rx_byte) data_bad = 1'b1;
            end
            @(negedge clk);
        end
        rx_byte_valid = 1'b0;
        rx_pkt_end = 1'b0;
        cpu_irq_ack = 1'b0;
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!fifo_wr_en, "R1", "fifo_wr_en", fifo_wr_en, 0);
        check(!hs_valid, "R1", "hs_valid", hs_valid, 0);
        check(!irq, "R1", "irq", irq, 0);
        check(ep_status == 3'b000, "R1", "ep_status", ep_status, 0);
        rst_n = 1'b1;

        foreach (VECS[k]) begin
            string rq;
            rq = $sformatf("R%0d", VECS[k].req);
            strobes(VECS[k].empty_first, VECS[k].ack_first);
            send_pkt(VECS[k].addr, VECS[k].ep, VECS[k].en, VECS[k].iso,
                     int'(VECS[k].nbytes), 1'b0);
            check(nwr == int'(VECS[k].exp_wr), rq, "write count", nwr, VECS[k].exp_wr);
            check(!data_bad, rq, "write data", data_bad, 0);
            check(hs_valid == VECS[k].exp_hsv && (!hs_valid || hs_code == VECS[k].exp_hs),
                  rq, "handshake", {hs_valid, hs_code}, {VECS[k].exp_hsv, VECS[k].exp_hs});
            check(irq == VECS[k].exp_irq, rq, "irq", irq, VECS[k].exp_irq);
            check(ep_status == VECS[k].exp_st, rq, "ep_status", ep_status, VECS[k].exp_st);
            @(negedge clk);
            // R5 handshake lasts one cycle
            check(!hs_valid, "R5", "hs pulse width", hs_valid, 0);
        end

        // R9 acknowledge colliding with a store: set wins
        strobes(1'b1, 1'b1);
        check(!irq && ep_status[0] == 1'b0, "R9", "irq/full before collide",
              {irq, ep_status[0]}, 0);
        send_pkt(MY_ADDR, MY_EP, 1'b1, 1'b0, 3, 1'b1);
        check(irq, "R9", "irq after collision", irq, 1);
        check(hs_valid && hs_code == 2'b01, "R9", "ACK on collision", hs_code, 1);
        // R9 plain acknowledge clears on the next cycle
        cpu_irq_ack = 1'b1;
        @(negedge clk);
        cpu_irq_ack = 1'b0;
        check(!irq, "R9", "irq after ack", irq, 0);
        // R10 full flag held until emptied
        check(ep_status[0], "R10", "full held", ep_status[0], 1);
        cpu_buf_emptied = 1'b1;
        @(negedge clk);
        cpu_buf_emptied = 1'b0;
        check(!ep_status[0], "R10", "full cleared", ep_status[0], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule